// File: doc/BRIEF.md
# Bidirectional latched bus transceiver

This block joins two bidirectional byte-wide ports, A and B, and carries data between them without inversion. Each direction has its own bank of level-sensitive latches and three active-low controls: a chip select that gates the whole direction, a latch control that makes the bank transparent while low and freezes it on its rising edge, and an output control that turns on the tri-state drive toward the far port. The A-to-B bank samples A and drives B; the B-to-A bank samples B and drives A.

When a direction's output is off, its far port is released to high impedance so another agent on that bus may drive it. A bank never samples its source port while the opposite direction is driving that same port, so it cannot capture the block's own output. A flag reports the case where both directions drive at once. A synchronous reset, taken through one clock stage, clears both banks to zero and leaves the output enables alone.

Top module: `xcvr_latched`

## Requirements
- R1: Data passes through unchanged in width and polarity: every one of the W (default 8) bits on the driven port equals the same bit held in that direction's bank.
- R2: While ab_sel_n and ab_load_n are both 0 (and the block is not driving A), the A-to-B bank follows the present value on port A.
- R3: On a 0-to-1 transition of ab_load_n with ab_sel_n at 0, the A-to-B bank keeps the A value present just before the edge and no longer follows A.
- R4: While ab_sel_n is 1, the A-to-B bank keeps its contents whatever ab_load_n and port A do.
- R5: Port B is driven with the A-to-B bank only when ab_sel_n and ab_drive_n are both 0; in the other three combinations port B is high impedance.
- R6: The B-to-A direction behaves as R2 to R5 with ba_sel_n, ba_load_n and ba_drive_n, sampling port B and driving port A.
- R7: A bank does not load while the opposite direction is driving its source port; it holds the value it had, so it never captures the block's own output.
- R8: With rst at 1 on a rising clk edge, both banks read all zeros from the following edge on until released; the output enables keep working during reset.
- R9: clash is 1 exactly when ab_sel_n, ab_drive_n, ba_sel_n and ba_drive_n are all 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the reset stage |
| rst | input | 1 | Synchronous active-high reset |
| ab_sel_n | input | 1 | A-to-B direction select, active low |
| ab_load_n | input | 1 | A-to-B latch control, transparent while low |
| ab_drive_n | input | 1 | A-to-B output enable onto B, active low |
| ba_sel_n | input | 1 | B-to-A direction select, active low |
| ba_load_n | input | 1 | B-to-A latch control, transparent while low |
| ba_drive_n | input | 1 | B-to-A output enable onto A, active low |
| port_a | inout | W | A side bus: source for A-to-B, driven by B-to-A |
| port_b | inout | W | B side bus: source for B-to-A, driven by A-to-B |
| clash | output | 1 | Both directions driving at once |

## Verification
The checker samples on every clock edge that a driven port carries its bank unchanged, that a direction never drives with its select or output control high, that an open bank matches its source port, that a deselected bank is stable and that the clash flag only rises with all four enables low. Capture on the rising latch edge, the high-impedance release (seen through bench pull-ups as all ones), the refusal to load from the block's own drive, and clearing by reset are shown by the directed scenarios, since they depend on ordered control sequences rather than a single-cycle relation.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // One direction's three active-low controls.
    typedef struct packed {
        logic sel_n;
        logic load_n;
        logic drive_n;
    } dir_ctl_t;

    // Decoded state of one direction.
    typedef struct packed {
        logic open;
        logic drive;
    } dir_stat_t;

    function automatic logic ctl_drives(input dir_ctl_t c);
        return !c.sel_n && !c.drive_n;
    endfunction

    function automatic logic ctl_opens(input dir_ctl_t c, input logic src_busy);
        return !c.sel_n && !c.load_n && !src_busy;
    endfunction

endpackage

// File: rtl/xcvr_rst_stage.sv
module xcvr_rst_stage (
    input  logic clk,
    input  logic rst,
    output logic clr
);
    always_ff @(posedge clk) begin
        clr <= rst;
    end
endmodule

// File: rtl/xcvr_dir_ctl.sv
module xcvr_dir_ctl
    import xcvr_pkg::*;
(
    input  dir_ctl_t  ctl,
    input  logic      src_busy,
    output dir_stat_t stat
);
    always_comb begin
        stat.open  = ctl_opens(ctl, src_busy);
        stat.drive = ctl_drives(ctl);
    end
endmodule

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
    parameter int W = 8
) (
    input  logic         clr,
    input  logic         open,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_latch begin
            if (clr)
                q[i] <= 1'b0;
            else if (open)
                q[i] <= d[i];
        end
    end
endmodule

// File: rtl/xcvr_latched.sv
module xcvr_latched
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ab_sel_n,
    input  logic         ab_load_n,
    input  logic         ab_drive_n,
    input  logic         ba_sel_n,
    input  logic         ba_load_n,
    input  logic         ba_drive_n,
    inout  wire  [W-1:0] port_a,
    inout  wire  [W-1:0] port_b,
    output logic         clash
);
    localparam logic [W-1:0] HIZ = {W{1'bz}};

    dir_ctl_t  ab_ctl, ba_ctl;
    dir_stat_t ab_st, ba_st;
    logic      clr_q;
    logic [W-1:0] q_ab, q_ba;

    assign ab_ctl = '{sel_n: ab_sel_n, load_n: ab_load_n, drive_n: ab_drive_n};
    assign ba_ctl = '{sel_n: ba_sel_n, load_n: ba_load_n, drive_n: ba_drive_n};

    xcvr_rst_stage u_rst (
        .clk (clk),
        .rst (rst),
        .clr (clr_q)
    );

    // A-to-B source is port A, which the B-to-A side may be driving.
    xcvr_dir_ctl u_ctl_ab (
        .ctl      (ab_ctl),
        .src_busy (ba_st.drive),
        .stat     (ab_st)
    );

    xcvr_dir_ctl u_ctl_ba (
        .ctl      (ba_ctl),
        .src_busy (ab_st.drive),
        .stat     (ba_st)
    );

    xcvr_latch_bank #(.W(W)) u_bank_ab (
        .clr  (clr_q),
        .open (ab_st.open),
        .d    (port_a),
        .q    (q_ab)
    );

    xcvr_latch_bank #(.W(W)) u_bank_ba (
        .clr  (clr_q),
        .open (ba_st.open),
        .d    (port_b),
        .q    (q_ba)
    );

    assign port_b = ab_st.drive ? q_ab : HIZ;
    assign port_a = ba_st.drive ? q_ba : HIZ;

    assign clash = ab_st.drive && ba_st.drive;

endmodule

// File: rtl/xcvr_latched_chk.sv
module xcvr_latched_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         clr_q,
    input logic         ab_sel_n,
    input logic         ab_load_n,
    input logic         ab_drive_n,
    input logic         ba_sel_n,
    input logic         ba_load_n,
    input logic         ba_drive_n,
    input logic [W-1:0] port_a,
    input logic [W-1:0] port_b,
    input logic [W-1:0] q_ab,
    input logic [W-1:0] q_ba,
    input logic         drv_ab,
    input logic         drv_ba,
    input logic         clash
);
    AST_B_CARRIES_BANK: assert property (@(posedge clk) disable iff (rst)
        drv_ab |-> (port_b == q_ab)); // R1
    AST_A_CARRIES_BANK: assert property (@(posedge clk) disable iff (rst)
        drv_ba |-> (port_a == q_ba)); // R6
    AST_B_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (ab_sel_n || ab_drive_n) |-> !drv_ab); // R5
    AST_A_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (ba_sel_n || ba_drive_n) |-> !drv_ba); // R6
    AST_AB_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!ab_sel_n && !ab_load_n && !drv_ba && !clr_q) |-> (q_ab == port_a)); // R2
    AST_BA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!ba_sel_n && !ba_load_n && !drv_ab && !clr_q) |-> (q_ba == port_b)); // R6
    AST_AB_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ab_sel_n && $past(ab_sel_n) && !clr_q && !$past(clr_q)) |-> $stable(q_ab)); // R4
    AST_CLASH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        clash |-> (!ab_sel_n && !ab_drive_n && !ba_sel_n && !ba_drive_n)); // R9
    AST_CLASH_SEEN: assert property (@(posedge clk) disable iff (rst)
        (!ab_sel_n && !ab_drive_n && !ba_sel_n && !ba_drive_n) |-> clash); // R9
endmodule

bind xcvr_latched xcvr_latched_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_q      (clr_q),
    .ab_sel_n   (ab_sel_n),
    .ab_load_n  (ab_load_n),
    .ab_drive_n (ab_drive_n),
    .ba_sel_n   (ba_sel_n),
    .ba_load_n  (ba_load_n),
    .ba_drive_n (ba_drive_n),
    .port_a     (port_a),
    .port_b     (port_b),
    .q_ab       (q_ab),
    .q_ba       (q_ba),
    .drv_ab     (ab_st.drive),
    .drv_ba     (ba_st.drive),
    .clash      (clash)
);

// File: tb/tb_xcvr_latched.sv
`timescale 1ns/1ps
module tb_xcvr_latched;
    localparam int W = 8;
    localparam logic [W-1:0] FLOAT = {W{1'b1}}; // released bus reads as pull-ups

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ab_sel_n = 1'b1, ab_load_n = 1'b1, ab_drive_n = 1'b1;
    logic ba_sel_n = 1'b1, ba_load_n = 1'b1, ba_drive_n = 1'b1;
    logic clash;
    logic [W-1:0] a_val = '0, b_val = '0;
    logic a_on = 1'b0, b_on = 1'b0;
    wire  [W-1:0] port_a, port_b;
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign port_a = a_on ? a_val : {W{1'bz}};
    assign port_b = b_on ? b_val : {W{1'bz}};

    for (genvar i = 0; i < W; i++) begin : g_pull
        pullup (port_a[i]);
        pullup (port_b[i]);
    end

    xcvr_latched #(.W(W)) dut (
        .clk        (clk),
        .rst        (rst),
        .ab_sel_n   (ab_sel_n),
        .ab_load_n  (ab_load_n),
        .ab_drive_n (ab_drive_n),
        .ba_sel_n   (ba_sel_n),
        .ba_load_n  (ba_load_n),
        .ba_drive_n (ba_drive_n),
        .port_a     (port_a),
        .port_b     (port_b),
        .clash      (clash)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic idle_all();
        step();
        ab_sel_n = 1; ab_load_n = 1; ab_drive_n = 1;
        ba_sel_n = 1; ba_load_n = 1; ba_drive_n = 1;
        a_on = 0; b_on = 0;
        settle();
    endtask

    task automatic t_reset();
        step();
        ab_sel_n = 0; ab_drive_n = 0;
        settle();
        check("R8 reset clears A-to-B bank, B driven", port_b, '0);
        check("R6 A released while B-to-A off", port_a, FLOAT);
        step();
        rst = 0;
        repeat (2) step();
        settle();
        check("R8 bank still zero after release", port_b, '0);
    endtask

    task automatic t_ab_transparent();
        idle_all();
        step();
        a_on = 1; a_val = 8'h3C;
        ab_sel_n = 0; ab_load_n = 0; ab_drive_n = 0;
        settle();
        check("R2 transparent follows A", port_b, 8'h3C);
        step();
        a_val = 8'h81;
        settle();
        check("R1 non-inverting edge bits", port_b, 8'h81);
        step();
        a_val = 8'h5A;
        settle();
        check("R2 follows new A", port_b, 8'h5A);
    endtask

    task automatic t_ab_capture();
        step();
        ab_load_n = 1;
        settle();
        step();
        a_val = 8'hC3;
        settle();
        check("R3 holds value before rising edge", port_b, 8'h5A);
    endtask

    task automatic t_ab_deselect_hold();
        step();
        ab_sel_n = 1;
        settle();
        check("R5 B released when select high", port_b, FLOAT);
        step();
        ab_load_n = 0; a_val = 8'h11;
        settle();
        step();
        ab_load_n = 1;
        settle();
        step();
        ab_sel_n = 0;
        settle();
        check("R4 bank unchanged while deselected", port_b, 8'h5A);
    endtask

    task automatic t_ab_enable_grid();
        for (int s = 0; s < 2; s++) begin
            for (int o = 0; o < 2; o++) begin
                step();
                ab_load_n = 1; ab_sel_n = s[0]; ab_drive_n = o[0];
                settle();
                check("R5 enable combination", port_b, (s == 0 && o == 0) ? 8'h5A : FLOAT);
            end
        end
    endtask

    task automatic t_ba_path();
        idle_all();
        step();
        b_on = 1; b_val = 8'h96;
        ba_sel_n = 0; ba_load_n = 0; ba_drive_n = 0;
        settle();
        check("R6 B-to-A transparent", port_a, 8'h96);
        step();
        ba_load_n = 1;
        settle();
        step();
        b_val = 8'h0F;
        settle();
        check("R6 B-to-A capture holds", port_a, 8'h96);
        step();
        ba_drive_n = 1;
        settle();
        check("R6 A released when output control high", port_a, FLOAT);
        step();
        ba_sel_n = 1; ba_load_n = 0;
        settle();
        step();
        ba_load_n = 1; ba_sel_n = 0; ba_drive_n = 0;
        settle();
        check("R6 B-to-A deselect hold", port_a, 8'h96);
    endtask

    task automatic t_own_drive();
        // B-to-A drives A with 96; A-to-B bank holds 5A and must not load it.
        step();
        b_on = 0;
        ab_sel_n = 0; ab_load_n = 0; ab_drive_n = 1;
        settle();
        check("R6 A driven with B-to-A bank", port_a, 8'h96);
        step();
        ab_load_n = 1;
        settle();
        step();
        ba_drive_n = 1; ba_sel_n = 1;
        settle();
        step();
        ab_drive_n = 0;
        settle();
        check("R7 A-to-B bank ignored own drive on A", port_b, 8'h5A);
    endtask

    task automatic t_clash();
        idle_all();
        step();
        ab_sel_n = 0; ab_drive_n = 0;
        settle();
        check("R9 one direction no clash", {7'b0, clash}, 8'h00);
        step();
        ba_sel_n = 0; ba_drive_n = 0;
        settle();
        check("R9 both driving raises clash", {7'b0, clash}, 8'h01);
        step();
        ba_drive_n = 1;
        settle();
        check("R9 clash clears", {7'b0, clash}, 8'h00);
    endtask

    task automatic t_reset_again();
        idle_all();
        step();
        ab_sel_n = 0; ab_drive_n = 0;
        settle();
        check("R8 contents before second reset", port_b, 8'h5A);
        step();
        rst = 1;
        settle();
        check("R8 no clear before clock edge", port_b, 8'h5A);
        step();
        settle();
        check("R8 cleared after clock edge", port_b, '0);
        step();
        rst = 0;
        repeat (2) step();
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        t_ab_transparent();
        t_ab_capture();
        t_ab_deselect_hold();
        t_ab_enable_grid();
        t_ba_path();
        t_own_drive();
        t_clash();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule